// File: doc/BRIEF.md
# Two-Segment Packet Assembler with Per-Segment CRC

The block turns one transmit descriptor into one outgoing packet. A descriptor names a header segment (up to 255 bytes) and a data segment (up to 16M-1 bytes). It carries two flags that each add an 8-bit CRC byte after their own segment, and a count of leading header bytes that are sent but kept out of the header CRC. The block fetches the bytes of each segment in order through its own request/acknowledge port. It then sends header, header CRC, data and data CRC as one byte stream with valid/ready flow control, and marks the final byte as end of packet.

Once the last byte has been accepted downstream, a one-cycle done pulse follows, and the block becomes ready for the next descriptor. A segment of length zero is skipped and its port never raises a request. A flagged CRC byte is still sent after an empty segment. A descriptor with both lengths zero produces no bytes and no end-of-packet marker, only the done pulse.

Top module: `seg_pkt_asm`

## Requirements
- R1: A packet is sent in the order header bytes, header CRC if flagged, data bytes, data CRC if flagged, and out_eop_o is high on the final byte only.
- R2: The header CRC starts at 0x00. Each counted header byte is fed into it least significant bit first: feedback = crc[7] xor bit, crc is shifted left by one, and crc is xored with 0x07 when feedback is 1. The result is sent as one byte right after the header when desc_hcrc_i was set.
- R3: The data CRC uses the same rule, restarts at 0x00, covers data bytes only, and is sent right after the data when desc_dcrc_i was set.
- R4: Header bytes at index below desc_skip_i are sent but not counted in the header CRC; a count equal to or above the header length gives a header CRC of 0x00.
- R5: A segment of length zero contributes no bytes and its request output stays low for the whole packet.
- R6: A flagged CRC byte is still sent, with value 0x00, after a segment of length zero when the other segment is not empty.
- R7: With both lengths zero, no byte is sent and done_o pulses in the cycle after the descriptor is accepted.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_byte_o and out_eop_o hold for the next cycle.
- R9: desc_ready_o is high only while idle (high after reset); done_o pulses for one cycle in the cycle after the end-of-packet byte is accepted, and desc_ready_o rises in the following cycle.
- R10: A byte moves on a fetch port in a cycle where its request and acknowledge are both high; indexes run 0, 1, 2 and so on without gaps or repeats, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Block idle, descriptor taken when valid |
| desc_hlen_i | input | HLEN_W | Header length in bytes |
| desc_dlen_i | input | DLEN_W | Data length in bytes |
| desc_hcrc_i | input | 1 | Append CRC after header |
| desc_dcrc_i | input | 1 | Append CRC after data |
| desc_skip_i | input | HLEN_W | Leading header bytes left out of the header CRC |
| hdr_req_o | output | 1 | Header byte wanted |
| hdr_idx_o | output | HLEN_W | Index of wanted header byte |
| hdr_ack_i | input | 1 | Header byte present on hdr_byte_i |
| hdr_byte_i | input | 8 | Header byte |
| dat_req_o | output | 1 | Data byte wanted |
| dat_idx_o | output | DLEN_W | Index of wanted data byte |
| dat_ack_i | input | 1 | Data byte present on dat_byte_i |
| dat_byte_i | input | 8 | Data byte |
| out_valid_o | output | 1 | Output byte valid |
| out_byte_o | output | 8 | Output byte |
| out_eop_o | output | 1 | Output byte is the last of the packet |
| out_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows at the ports within the packet in which it occurs. A segment can be dropped or repeated, a CRC byte can be missing or extra, or the end-of-packet flag can sit on the wrong byte. Any of these breaks the compare of the received stream against the stream built from the descriptor, and it leaves the done pulse off by at least one cycle from the end-of-packet handshake. A corrupt CRC register shows as a wrong byte right after the segment it covers, and a wrong fetch index is visible on the request port in the very cycle it is issued.

// File: rtl/seg_pkt_pkg.sv
package seg_pkt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_HCRC, S_DAT, S_DCRC, S_TAIL, S_DONE
  } seg_state_e;

  typedef enum logic [1:0] {
    SRC_HDR, SRC_DAT, SRC_CRC
  } seg_src_e;

  // next packet element after s; hz/dz: segment lengths are zero
  function automatic seg_state_e seg_after(seg_state_e s, logic hz, logic dz,
                                           logic hc, logic dc);
    if (s == S_IDLE) begin
      if (hz && dz) return S_DONE;
      if (!hz) return S_HDR;
    end
    if ((s == S_IDLE || s == S_HDR) && hc) return S_HCRC;
    if ((s == S_IDLE || s == S_HDR || s == S_HCRC) && !dz) return S_DAT;
    if ((s == S_IDLE || s == S_HDR || s == S_HCRC || s == S_DAT) && dc) return S_DCRC;
    return S_TAIL;
  endfunction
endpackage

// File: rtl/seg_crc_acc.sv
module seg_crc_acc #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic [W-1:0] chain [W+1];

  assign chain[0] = crc_q;

  // one shift stage per input bit, lsb first
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][W-1] ^ byte_i[g];
    assign chain[g+1] = {chain[g][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= chain[W];
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] byte_i,
  input  logic         last_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] byte_o,
  output logic         eop_o,
  output logic         free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
      eop_o   <= 1'b0;
    end else if (ld_i) begin
      valid_o <= 1'b1;
      byte_o  <= byte_i;
      eop_o   <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_pkt_ctrl.sv
module seg_pkt_ctrl
  import seg_pkt_pkg::*;
#(
  parameter int unsigned HLEN_W = 8,
  parameter int unsigned DLEN_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [HLEN_W-1:0] desc_hlen_i,
  input  logic [DLEN_W-1:0] desc_dlen_i,
  input  logic              desc_hcrc_i,
  input  logic              desc_dcrc_i,
  input  logic [HLEN_W-1:0] desc_skip_i,
  output logic              hdr_req_o,
  output logic [HLEN_W-1:0] hdr_idx_o,
  input  logic              hdr_ack_i,
  output logic              dat_req_o,
  output logic [DLEN_W-1:0] dat_idx_o,
  input  logic              dat_ack_i,
  input  logic              out_free_i,
  input  logic              out_hs_i,
  output logic              ld_o,
  output logic              last_o,
  output seg_src_e          src_o,
  output logic              crc_en_o,
  output logic              crc_clr_o,
  output logic              done_o
);
  seg_state_e        st_q, st_d, succ;
  logic [HLEN_W-1:0] hlen_q, skip_q;
  logic [DLEN_W-1:0] dlen_q, idx_q, idx_d;
  logic              hc_q, dc_q;
  logic              h_last, d_last;

  assign succ   = seg_after(st_q, hlen_q == '0, dlen_q == '0, hc_q, dc_q);
  assign h_last = idx_q[HLEN_W-1:0] == hlen_q - HLEN_W'(1);
  assign d_last = idx_q == dlen_q - DLEN_W'(1);

  assign hdr_idx_o = idx_q[HLEN_W-1:0];
  assign dat_idx_o = idx_q;

  always_comb begin
    st_d         = st_q;
    idx_d        = idx_q;
    desc_ready_o = 1'b0;
    hdr_req_o    = 1'b0;
    dat_req_o    = 1'b0;
    ld_o         = 1'b0;
    last_o       = 1'b0;
    src_o        = SRC_CRC;
    crc_en_o     = 1'b0;
    crc_clr_o    = 1'b0;
    done_o       = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        desc_ready_o = 1'b1;
        if (desc_valid_i) begin
          st_d      = seg_after(S_IDLE, desc_hlen_i == '0, desc_dlen_i == '0,
                                desc_hcrc_i, desc_dcrc_i);
          idx_d     = '0;
          crc_clr_o = 1'b1;
        end
      end
      S_HDR: begin
        hdr_req_o = out_free_i;
        src_o     = SRC_HDR;
        if (hdr_req_o && hdr_ack_i) begin
          ld_o     = 1'b1;
          crc_en_o = idx_q[HLEN_W-1:0] >= skip_q;
          last_o   = h_last && (succ == S_TAIL);
          if (h_last) begin
            st_d  = succ;
            idx_d = '0;
          end else begin
            idx_d = idx_q + DLEN_W'(1);
          end
        end
      end
      S_DAT: begin
        dat_req_o = out_free_i;
        src_o     = SRC_DAT;
        if (dat_req_o && dat_ack_i) begin
          ld_o     = 1'b1;
          crc_en_o = 1'b1;
          last_o   = d_last && (succ == S_TAIL);
          if (d_last) begin
            st_d  = succ;
            idx_d = '0;
          end else begin
            idx_d = idx_q + DLEN_W'(1);
          end
        end
      end
      S_HCRC, S_DCRC: begin
        if (out_free_i) begin
          ld_o   = 1'b1;
          last_o = succ == S_TAIL;
          st_d   = succ;
        end
      end
      S_TAIL: if (out_hs_i) st_d = S_DONE;
      S_DONE: begin
        done_o = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    // data CRC starts from zero whatever came before it
    if (st_d != st_q && (st_d == S_DAT || (st_d == S_DCRC && st_q != S_DAT)))
      crc_clr_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      hlen_q <= '0;
      dlen_q <= '0;
      skip_q <= '0;
      hc_q   <= 1'b0;
      dc_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (desc_ready_o && desc_valid_i) begin
        hlen_q <= desc_hlen_i;
        dlen_q <= desc_dlen_i;
        skip_q <= desc_skip_i;
        hc_q   <= desc_hcrc_i;
        dc_q   <= desc_dcrc_i;
      end
    end
  end
endmodule

// File: rtl/seg_pkt_asm.sv
module seg_pkt_asm
  import seg_pkt_pkg::*;
#(
  parameter int unsigned HLEN_W = 8,
  parameter int unsigned DLEN_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [HLEN_W-1:0] desc_hlen_i,
  input  logic [DLEN_W-1:0] desc_dlen_i,
  input  logic              desc_hcrc_i,
  input  logic              desc_dcrc_i,
  input  logic [HLEN_W-1:0] desc_skip_i,
  output logic              hdr_req_o,
  output logic [HLEN_W-1:0] hdr_idx_o,
  input  logic              hdr_ack_i,
  input  logic [7:0]        hdr_byte_i,
  output logic              dat_req_o,
  output logic [DLEN_W-1:0] dat_idx_o,
  input  logic              dat_ack_i,
  input  logic [7:0]        dat_byte_i,
  output logic              out_valid_o,
  output logic [7:0]        out_byte_o,
  output logic              out_eop_o,
  input  logic              out_ready_i,
  output logic              done_o
);
  logic              out_free, out_hs;
  logic              ld, last, crc_en, crc_clr;
  seg_src_e          src;
  logic [BYTE_W-1:0] ld_byte, crc;

  assign out_hs = out_valid_o && out_ready_i;

  seg_pkt_ctrl #(.HLEN_W(HLEN_W), .DLEN_W(DLEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .desc_valid_i, .desc_ready_o, .desc_hlen_i, .desc_dlen_i,
    .desc_hcrc_i, .desc_dcrc_i, .desc_skip_i,
    .hdr_req_o, .hdr_idx_o, .hdr_ack_i,
    .dat_req_o, .dat_idx_o, .dat_ack_i,
    .out_free_i (out_free),
    .out_hs_i   (out_hs),
    .ld_o       (ld),
    .last_o     (last),
    .src_o      (src),
    .crc_en_o   (crc_en),
    .crc_clr_o  (crc_clr),
    .done_o
  );

  always_comb begin
    unique case (src)
      SRC_HDR: ld_byte = hdr_byte_i;
      SRC_DAT: ld_byte = dat_byte_i;
      default: ld_byte = crc;
    endcase
  end

  seg_crc_acc #(.W(BYTE_W), .POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .byte_i (ld_byte),
    .crc_o  (crc)
  );

  seg_out_stage #(.W(BYTE_W)) u_out (
    .clk_i, .rst_ni,
    .ld_i    (ld),
    .byte_i  (ld_byte),
    .last_i  (last),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .byte_o  (out_byte_o),
    .eop_o   (out_eop_o),
    .free_o  (out_free)
  );
endmodule

// File: rtl/seg_pkt_asm_chk.sv
module seg_pkt_asm_chk #(
  parameter int unsigned HLEN_W = 8,
  parameter int unsigned DLEN_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              desc_valid_i,
  input logic              desc_ready_o,
  input logic [HLEN_W-1:0] desc_hlen_i,
  input logic [DLEN_W-1:0] desc_dlen_i,
  input logic              hdr_req_o,
  input logic              dat_req_o,
  input logic              out_valid_o,
  input logic [7:0]        out_byte_o,
  input logic              out_eop_o,
  input logic              out_ready_i,
  input logic              done_o
);
  logic hz_l, dz_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hz_l <= 1'b0;
      dz_l <= 1'b0;
    end else if (desc_valid_i && desc_ready_o) begin
      hz_l <= desc_hlen_i == '0;
      dz_l <= desc_dlen_i == '0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o) && $stable(out_eop_o));

  p_done_after_eop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_eop_o |=> done_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && desc_ready_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |-> !out_valid_o && !hdr_req_o && !dat_req_o && !done_o);

  p_empty_desc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && desc_ready_o && desc_hlen_i == '0 && desc_dlen_i == '0
    |=> done_o && !out_valid_o);

  p_no_empty_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_ready_o |-> !(dz_l && dat_req_o) && !(hz_l && hdr_req_o));

  p_req_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_req_o && dat_req_o));
endmodule

bind seg_pkt_asm seg_pkt_asm_chk #(.HLEN_W(HLEN_W), .DLEN_W(DLEN_W)) u_chk (
  .clk_i, .rst_ni, .desc_valid_i, .desc_ready_o, .desc_hlen_i, .desc_dlen_i,
  .hdr_req_o, .dat_req_o, .out_valid_o, .out_byte_o, .out_eop_o, .out_ready_i, .done_o
);

// File: tb/seg_pkt_asm_bench.sv
`timescale 1ns/1ps
module seg_pkt_asm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [7:0]  desc_hlen = '0;
  logic [23:0] desc_dlen = '0;
  logic        desc_hcrc = 1'b0, desc_dcrc = 1'b0;
  logic [7:0]  desc_skip = '0;
  logic        hdr_req, dat_req;
  logic [7:0]  hdr_idx;
  logic [23:0] dat_idx;
  logic        hdr_ack = 1'b0, dat_ack = 1'b0;
  logic [7:0]  hdr_byte, dat_byte;
  logic        out_valid, out_eop;
  logic [7:0]  out_byte;
  logic        out_ready = 1'b0;
  logic        done;

  int total = 0, bad = 0;
  int cyc = 0;
  int salt = 0;
  int rdy_mode = 0, ack_mode = 0;

  logic [8:0] exp_q[$];
  int cur_hlen, cur_dlen;
  int rx_cnt, mism, first_pos, hidx_exp, didx_exp, idx_err, zreq_err, hold_err;
  int eop_cyc, acc_cyc, done_cyc, done_seen;
  logic [8:0] first_act, first_exp;
  bit rdy_at_done;
  logic pv, pr, pe;
  logic [7:0] pb;

  always #4 clk = ~clk;

  function automatic logic [7:0] hb(int i, int s);
    return 8'((i * 29) ^ (s * 5 + 1));
  endfunction

  function automatic logic [7:0] db(int i, int s);
    return 8'(i * 7 + s * 13 + (i >> 3));
  endfunction

  function automatic logic [7:0] crc_b(logic [7:0] c, logic [7:0] d);
    logic f;
    for (int i = 0; i < 8; i++) begin
      f = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (f) c = c ^ 8'h07;
    end
    return c;
  endfunction

  assign hdr_byte = hb(int'(hdr_idx), salt);
  assign dat_byte = db(int'(dat_idx), salt);

  seg_pkt_asm u_seg_pkt_asm (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
    .desc_hlen_i(desc_hlen), .desc_dlen_i(desc_dlen),
    .desc_hcrc_i(desc_hcrc), .desc_dcrc_i(desc_dcrc), .desc_skip_i(desc_skip),
    .hdr_req_o(hdr_req), .hdr_idx_o(hdr_idx), .hdr_ack_i(hdr_ack), .hdr_byte_i(hdr_byte),
    .dat_req_o(dat_req), .dat_idx_o(dat_idx), .dat_ack_i(dat_ack), .dat_byte_i(dat_byte),
    .out_valid_o(out_valid), .out_byte_o(out_byte), .out_eop_o(out_eop),
    .out_ready_i(out_ready), .done_o(done)
  );

  task automatic chk(string tag, string what, bit ok, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit pick(int mode);
    case (mode)
      0: return 1'b1;
      1: return ($urandom % 2) == 0;
      default: return ($urandom % 5) == 0;
    endcase
  endfunction

  // cycle count and global watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // randomized flow control, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = pick(rdy_mode);
      hdr_ack   = pick(ack_mode);
      dat_ack   = pick(ack_mode);
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hdr_req && hdr_ack) begin
        if (int'(hdr_idx) != hidx_exp) idx_err++;
        hidx_exp++;
      end
      if (dat_req && dat_ack) begin
        if (int'(dat_idx) != didx_exp) idx_err++;
        didx_exp++;
      end
      if (hdr_req && dat_req) idx_err++;
      if ((hdr_req && cur_hlen == 0) || (dat_req && cur_dlen == 0)) zreq_err++;
      if (pv && !pr && (!out_valid || out_byte != pb || out_eop != pe)) hold_err++;
      pv = out_valid; pr = out_ready; pb = out_byte; pe = out_eop;
      if (out_valid && out_ready) begin
        if (rx_cnt >= exp_q.size() || {out_eop, out_byte} != exp_q[rx_cnt]) begin
          if (mism == 0) begin
            first_pos = rx_cnt;
            first_act = {out_eop, out_byte};
            first_exp = (rx_cnt < exp_q.size()) ? exp_q[rx_cnt] : 9'h1ff;
          end
          mism++;
        end
        rx_cnt++;
        if (out_eop) eop_cyc = cyc;
      end
      if (desc_valid && desc_ready) acc_cyc = cyc;
      if (done) begin
        done_cyc = cyc;
        done_seen++;
        rdy_at_done = desc_ready;
      end
    end
  end

  task automatic run_pkt(string tag, int hl, int dl, bit hc, bit dc, int sk);
    logic [7:0] c;
    logic [8:0] t;
    int w;
    while (!desc_ready) begin
      @(posedge clk);
      #1;
    end
    salt++;
    exp_q.delete();
    if (hl != 0 || dl != 0) begin
      c = 8'h00;
      for (int i = 0; i < hl; i++) begin
        exp_q.push_back({1'b0, hb(i, salt)});
        if (i >= sk) c = crc_b(c, hb(i, salt));
      end
      if (hc) exp_q.push_back({1'b0, c});
      c = 8'h00;
      for (int i = 0; i < dl; i++) begin
        exp_q.push_back({1'b0, db(i, salt)});
        c = crc_b(c, db(i, salt));
      end
      if (dc) exp_q.push_back({1'b0, c});
      t = exp_q.pop_back();
      t[8] = 1'b1;
      exp_q.push_back(t);
    end
    cur_hlen = hl; cur_dlen = dl;
    rx_cnt = 0; mism = 0; hidx_exp = 0; didx_exp = 0;
    idx_err = 0; zreq_err = 0; hold_err = 0;
    eop_cyc = -100; acc_cyc = -100; done_cyc = -1; done_seen = 0;
    desc_hlen = 8'(hl); desc_dlen = 24'(dl); desc_hcrc = hc; desc_dcrc = dc;
    desc_skip = 8'(sk); desc_valid = 1'b1;
    @(posedge clk);
    #1;
    desc_valid = 1'b0;
    w = 0;
    while (done_seen == 0 && w < 30000) begin
      @(posedge clk);
      #1;
      w++;
    end
    chk(tag, "done seen", done_seen == 1, done_seen, 1);
    chk(tag, "byte count", rx_cnt == exp_q.size(), rx_cnt, exp_q.size());
    if (mism != 0)
      $display("FAIL %s stream pos=%0d actual=%h expected=%h", tag, first_pos, first_act, first_exp);
    total++;
    if (mism != 0) bad++;
    chk("R8", "hold while stalled", hold_err == 0, hold_err, 0);
    chk("R10", "fetch index order", idx_err == 0, idx_err, 0);
    chk("R5", "request on empty segment", zreq_err == 0, zreq_err, 0);
    if (exp_q.size() == 0)
      chk("R7", "done after accept", done_cyc == acc_cyc + 1, done_cyc, acc_cyc + 1);
    else
      chk("R9", "done after eop", done_cyc == eop_cyc + 1, done_cyc, eop_cyc + 1);
    chk("R9", "ready low at done", rdy_at_done == 1'b0, rdy_at_done, 0);
    chk("R9", "ready after done", desc_ready == 1'b1, desc_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    cur_hlen = 1; cur_dlen = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset ready", desc_ready == 1'b1, desc_ready, 1);
    chk("R9", "reset quiet", !out_valid && !done && !hdr_req && !dat_req,
        {out_valid, done, hdr_req, dat_req}, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    rdy_mode = 0; ack_mode = 0;
    run_pkt("R7", 0, 0, 1, 1, 0);
    run_pkt("R7", 0, 0, 0, 0, 0);
    run_pkt("R1", 6, 6, 1, 1, 1);
    run_pkt("R2", 12, 0, 1, 0, 3);
    run_pkt("R3", 0, 9, 0, 1, 0);
    run_pkt("R3", 7, 9, 0, 1, 0);
    run_pkt("R4", 4, 3, 1, 1, 4);
    run_pkt("R4", 4, 3, 1, 1, 200);
    run_pkt("R6", 0, 6, 1, 0, 0);
    run_pkt("R6", 5, 0, 0, 1, 2);
    run_pkt("R6", 0, 1, 1, 1, 0);
    run_pkt("R5", 0, 10, 0, 0, 0);
    run_pkt("R5", 8, 0, 0, 0, 0);
    run_pkt("R1", 1, 1, 0, 0, 0);
    run_pkt("R2", 255, 3, 1, 1, 0);
    run_pkt("R10", 2, 300, 0, 1, 0);
    rdy_mode = 2; ack_mode = 1;
    run_pkt("R8", 10, 10, 1, 1, 2);
    rdy_mode = 1; ack_mode = 2;
    run_pkt("R8", 3, 20, 1, 1, 0);
    for (int n = 0; n < 30; n++) begin
      rdy_mode = $urandom % 3;
      ack_mode = $urandom % 3;
      run_pkt("R1", $urandom % 48, $urandom % 64, 1'($urandom), 1'($urandom), $urandom % 12);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule